// File: doc/BRIEF.md
# Threshold-Paced Transfer FIFO

This block is a sixteen-byte first-in first-out buffer placed between a host byte bus and a disk-side byte engine while a data transfer runs. In the disk-to-host direction the disk side pushes bytes and the host drains them. In the host-to-disk direction the host fills the buffer and the disk side takes the bytes out. A third direction, verify, moves bytes like a read, but the host-side cycles only consume them and put no data on the host bus.

The host is called for service through a request that depends on a programmed threshold. The request goes out as a DMA request when DMA is enabled, or as an interrupt flag when it is not. Once raised, it stays up until the host has emptied the buffer (read and verify) or filled it (write). DMA requests can follow a single-transfer handshake, which drops the request for one cycle after every acknowledge, or a burst handshake, which keeps it up throughout. With the buffer disabled the block holds a single byte, so every byte needs its own service. The disk side gets sticky overrun and underrun flags.

Top module: `tf_dma_fifo`

## Requirements
- R1: While reset is asserted and in the first cycle after it, the level is 0, both overrun and underrun flags are 0, and dma_req is 0. In the read direction host_irq is also 0.
- R2: Bytes leave in the order they entered, in both directions. The level goes up by one for each accepted push and down by one for each accepted pop.
- R3: With the buffer enabled, a read or verify direction (cfg_xfer 0 or 2) and threshold code c, the request rises on the clock edge that brings a non-zero level to 16-(c+1) or more.
- R4: With the buffer enabled, the write direction (cfg_xfer 1) and threshold code c, the request rises on the clock edge that leaves the level at c+1 or less while not full.
- R5: Once raised, the request stays up until the level reaches 0 (read and verify) or the capacity (write). It drops on that same edge.
- R6: When cfg_dma_en is 1 the request appears only on dma_req and host_irq stays 0. When cfg_dma_en is 0 it appears only on host_irq and dma_req stays 0.
- R7: In single-transfer mode (cfg_burst_en 0), dma_req is 0 in the cycle after each dma_ack. It returns in the following cycle if the request is still active.
- R8: In burst mode (cfg_burst_en 1), dma_req stays 1 through back-to-back acknowledges until the level reaches the end condition of R5.
- R9: In the verify direction each dma_ack removes one byte, and host_rdata stays 0 at all times.
- R10: With cfg_fifo_en 0 the capacity is one byte. The request is up exactly while one byte is held (read) or while none is held (write).
- R11: A disk push in the read or verify direction while the buffer is full sets the sticky overrun flag, discards the byte and leaves the level unchanged.
- R12: A disk pop in the write direction while the buffer is empty sets the sticky underrun flag and leaves the level at 0.
- R13: A host write into a full buffer and a host read from an empty buffer are ignored: the level is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_fifo_en | input | 1 | 1: sixteen-byte buffer, 0: one-byte buffer |
| cfg_thresh | input | 4 | Threshold code c; the effective threshold is c+1 |
| cfg_dma_en | input | 1 | Request goes out as DMA (1) or as an interrupt (0) |
| cfg_burst_en | input | 1 | Burst (1) or single-transfer (0) DMA handshake |
| cfg_xfer | input | 2 | Direction: 0 read, 1 write, 2 verify |
| host_rd | input | 1 | Host non-DMA byte read |
| host_wr | input | 1 | Host non-DMA byte write |
| host_wdata | input | 8 | Host write data |
| dma_ack | input | 1 | DMA acknowledge; moves one byte on the host side |
| host_rdata | output | 8 | Head byte toward the host (read direction only) |
| dsk_push | input | 1 | Disk-side byte push (read, verify) |
| dsk_wdata | input | 8 | Disk-side push data |
| dsk_pop | input | 1 | Disk-side byte pop (write) |
| dsk_rdata | output | 8 | Head byte toward the disk side (write direction) |
| dma_req | output | 1 | DMA service request |
| host_irq | output | 1 | Non-DMA service request |
| level | output | 5 | Bytes currently held |
| ovr_flag | output | 1 | Sticky disk-side overrun |
| und_flag | output | 1 | Sticky disk-side underrun |

## Verification
The hardest behaviour to reach from the ports is the hysteresis of the request. In the read direction the request must stay up while the level falls back below the arming point, and in the write direction while it climbs back above it. That happens only when one direction crosses the threshold and the opposite direction then moves the level back through it. The bench sweeps all sixteen threshold codes in both directions. For each code it fills and then drains the buffer one byte at a time, and after every byte it compares the request with a value worked out from the level and the code. It uses burst DMA for read and interrupt mode for write, and runs separate passes for the single-transfer gap, verify, the one-byte mode and the overrun and underrun edges.

// File: rtl/tf_pkg.sv
// Shared types for the threshold-paced transfer FIFO.
package tf_pkg;
    // Transfer direction as driven on cfg_xfer.
    typedef enum logic [1:0] {
        XF_READ   = 2'd0,
        XF_WRITE  = 2'd1,
        XF_VERIFY = 2'd2
    } xfer_e;
endpackage

// File: rtl/tf_store.sv
// Circular byte store with a level counter.
// Assumes push and pop are already qualified by the caller: no push when
// full, no pop when empty. The head is presented combinationally.
module tf_store #(
    parameter int DW    = 8,
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH),
    localparam int LW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [DW-1:0] push_data,
    input  logic          pop,
    output logic [DW-1:0] head,
    output logic [LW-1:0] level
);
    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wr_ptr;
    logic [AW-1:0] rd_ptr;

    // Store the incoming byte at the write pointer.
    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= push_data;
    end

    // Advance the pointers and track the level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else begin
            if (push) wr_ptr <= wr_ptr + AW'(1);
            if (pop)  rd_ptr <= rd_ptr + AW'(1);
            level <= level + LW'(push) - LW'(pop);
        end
    end

    // Present the oldest byte.
    assign head = mem[rd_ptr];
endmodule

// File: rtl/tf_req.sv
// Service request generator.
// Arms on the level that the current edge produces, then holds until the
// drain (read) or fill (write) end point. Routes the request to a DMA or
// an interrupt output, and inserts the single-transfer gap after each ack.
module tf_req #(
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH),
    localparam int LW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          is_read,
    input  logic [LW-1:0] level_nxt,
    input  logic [LW-1:0] cap,
    input  logic [LW-1:0] thr,
    input  logic          dma_en,
    input  logic          burst_en,
    input  logic          ack,
    output logic          dma_req,
    output logic          host_irq
);
    logic [LW-1:0] free_nxt;
    logic          arm;
    logic          done;
    logic          active_q;
    logic          gap_q;

    // Work out the arm and end conditions for the coming level.
    always_comb begin
        free_nxt = cap - level_nxt;
        if (is_read) begin
            arm  = (level_nxt != '0) && (free_nxt <= thr);
            done = (level_nxt == '0);
        end else begin
            arm  = (level_nxt <= thr) && (level_nxt != cap);
            done = (level_nxt == cap);
        end
    end

    // Keep the request active from arming until the end point; record acks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            gap_q    <= 1'b0;
        end else begin
            active_q <= (active_q | arm) & ~done;
            gap_q    <= ack;
        end
    end

    // Route the request to the DMA or the interrupt output.
    assign dma_req  = dma_en & active_q & (burst_en | ~gap_q);
    assign host_irq = ~dma_en & active_q;
endmodule

// File: rtl/tf_dma_fifo.sv
// Threshold-paced transfer FIFO, top level.
// Steers the host-side and disk-side strobes into push and pop according
// to the direction, refuses moves past full or empty, keeps the sticky
// disk-side error flags and gates the data outputs.
// Assumes the configuration inputs are held steady during a transfer.
module tf_dma_fifo
    import tf_pkg::*;
#(
    parameter int DW    = 8,
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH),
    localparam int LW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_fifo_en,
    input  logic [AW-1:0] cfg_thresh,
    input  logic          cfg_dma_en,
    input  logic          cfg_burst_en,
    input  logic [1:0]    cfg_xfer,
    input  logic          host_rd,
    input  logic          host_wr,
    input  logic [DW-1:0] host_wdata,
    input  logic          dma_ack,
    output logic [DW-1:0] host_rdata,
    input  logic          dsk_push,
    input  logic [DW-1:0] dsk_wdata,
    input  logic          dsk_pop,
    output logic [DW-1:0] dsk_rdata,
    output logic          dma_req,
    output logic          host_irq,
    output logic [LW-1:0] level,
    output logic          ovr_flag,
    output logic          und_flag
);
    xfer_e         xf;
    logic          is_read;
    logic [LW-1:0] cap;
    logic [LW-1:0] thr;
    logic          full;
    logic          empty;
    logic          push_req;
    logic          pop_req;
    logic [DW-1:0] push_data;
    logic          push_ok;
    logic          pop_ok;
    logic [LW-1:0] level_nxt;
    logic [DW-1:0] head;

    assign xf      = xfer_e'(cfg_xfer);
    assign is_read = (xf != XF_WRITE);

    // Capacity and effective threshold; a disabled buffer holds one byte.
    always_comb begin
        if (cfg_fifo_en) begin
            cap = LW'(DEPTH);
            thr = LW'(cfg_thresh) + LW'(1);
        end else begin
            cap = LW'(1);
            thr = LW'(1);
        end
    end

    // Steer strobes by direction and refuse moves past the limits.
    always_comb begin
        full      = (level == cap);
        empty     = (level == '0);
        push_req  = is_read ? dsk_push  : (host_wr | dma_ack);
        push_data = is_read ? dsk_wdata : host_wdata;
        pop_req   = is_read ? (host_rd | dma_ack) : dsk_pop;
        push_ok   = push_req & ~full;
        pop_ok    = pop_req & ~empty;
        level_nxt = level + LW'(push_ok) - LW'(pop_ok);
    end

    // Latch disk-side overrun and underrun until reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovr_flag <= 1'b0;
            und_flag <= 1'b0;
        end else begin
            if (is_read && dsk_push && full)   ovr_flag <= 1'b1;
            if (!is_read && dsk_pop && empty)  und_flag <= 1'b1;
        end
    end

    // Gate the head onto the data outputs.
    always_comb begin
        host_rdata = (xf == XF_READ && !empty) ? head : '0;
        dsk_rdata  = (!is_read && !empty)      ? head : '0;
    end

    tf_store #(.DW(DW), .DEPTH(DEPTH)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push_ok),
        .push_data (push_data),
        .pop       (pop_ok),
        .head      (head),
        .level     (level)
    );

    tf_req #(.DEPTH(DEPTH)) u_req (
        .clk       (clk),
        .rst_n     (rst_n),
        .is_read   (is_read),
        .level_nxt (level_nxt),
        .cap       (cap),
        .thr       (thr),
        .dma_en    (cfg_dma_en),
        .burst_en  (cfg_burst_en),
        .ack       (dma_ack),
        .dma_req   (dma_req),
        .host_irq  (host_irq)
    );
endmodule

// File: rtl/tf_dma_fifo_chk.sv
// Property checker for tf_dma_fifo, attached by bind.
module tf_dma_fifo_chk #(
    parameter int DW    = 8,
    parameter int DEPTH = 16,
    localparam int LW   = $clog2(DEPTH) + 1
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cfg_dma_en,
    input logic          cfg_burst_en,
    input logic [1:0]    cfg_xfer,
    input logic          dma_ack,
    input logic [DW-1:0] host_rdata,
    input logic          dma_req,
    input logic          host_irq,
    input logic [LW-1:0] level,
    input logic          ovr_flag,
    input logic          und_flag
);
    // R6: the two request outputs never overlap.
    a_r6_one_output: assert property (@(posedge clk) disable iff (!rst_n)
        !(dma_req && host_irq));

    // R6: no DMA request while DMA is off.
    a_r6_no_dma_off: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_dma_en |-> !dma_req);

    // R5: an empty buffer in a read direction has no request pending.
    a_r5_read_idle_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_xfer != 2'd1 && level == '0) |-> (!dma_req && !host_irq));

    // R7: single-transfer gap after an acknowledged cycle.
    a_r7_single_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_dma_en && !cfg_burst_en && dma_req && dma_ack) |=> !dma_req);

    // R9: verify never drives host data.
    a_r9_verify_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_xfer == 2'd2) |-> (host_rdata == '0));

    // R11: overrun is sticky.
    a_r11_ovr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_flag |=> ovr_flag);

    // R12: underrun is sticky.
    a_r12_und_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        und_flag |=> und_flag);

    // R2: the level never exceeds the depth.
    a_r2_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
        level <= LW'(DEPTH));
endmodule

bind tf_dma_fifo tf_dma_fifo_chk #(.DW(DW), .DEPTH(DEPTH)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_dma_en   (cfg_dma_en),
    .cfg_burst_en (cfg_burst_en),
    .cfg_xfer     (cfg_xfer),
    .dma_ack      (dma_ack),
    .host_rdata   (host_rdata),
    .dma_req      (dma_req),
    .host_irq     (host_irq),
    .level        (level),
    .ovr_flag     (ovr_flag),
    .und_flag     (und_flag)
);

// File: tb/tf_dma_fifo_bench.sv
// Sweep bench for tf_dma_fifo; expected values computed from level and code.
module tf_dma_fifo_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_fifo_en = 1'b1;
    logic [3:0] cfg_thresh = '0;
    logic       cfg_dma_en = 1'b0;
    logic       cfg_burst_en = 1'b0;
    logic [1:0] cfg_xfer = 2'd0;
    logic       host_rd = 1'b0;
    logic       host_wr = 1'b0;
    logic [7:0] host_wdata = '0;
    logic       dma_ack = 1'b0;
    logic [7:0] host_rdata;
    logic       dsk_push = 1'b0;
    logic [7:0] dsk_wdata = '0;
    logic       dsk_pop = 1'b0;
    logic [7:0] dsk_rdata;
    logic       dma_req;
    logic       host_irq;
    logic [4:0] level;
    logic       ovr_flag;
    logic       und_flag;

    int n_run  = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    tf_dma_fifo u_tf_dma_fifo (
        .clk(clk), .rst_n(rst_n), .cfg_fifo_en(cfg_fifo_en), .cfg_thresh(cfg_thresh),
        .cfg_dma_en(cfg_dma_en), .cfg_burst_en(cfg_burst_en), .cfg_xfer(cfg_xfer),
        .host_rd(host_rd), .host_wr(host_wr), .host_wdata(host_wdata), .dma_ack(dma_ack),
        .host_rdata(host_rdata), .dsk_push(dsk_push), .dsk_wdata(dsk_wdata),
        .dsk_pop(dsk_pop), .dsk_rdata(dsk_rdata), .dma_req(dma_req), .host_irq(host_irq),
        .level(level), .ovr_flag(ovr_flag), .und_flag(und_flag)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic restart(input logic [1:0] xf, input logic en, input logic [3:0] code,
                           input logic dma, input logic burst);
        cfg_xfer = xf; cfg_fifo_en = en; cfg_thresh = code;
        cfg_dma_en = dma; cfg_burst_en = burst;
        rst_n = 1'b0;
        tick(); tick();
        rst_n = 1'b1;
        tick();
    endtask

    task automatic push_dsk(input logic [7:0] d);
        dsk_push = 1'b1; dsk_wdata = d; tick(); dsk_push = 1'b0;
    endtask

    task automatic wr_host(input logic [7:0] d);
        host_wr = 1'b1; host_wdata = d; tick(); host_wr = 1'b0;
    endtask

    task automatic ack_once();
        dma_ack = 1'b1; tick(); dma_ack = 1'b0;
    endtask

    function automatic logic [7:0] pat(input int i, input int c);
        return 8'((i * 37 + c * 11 + 5) & 255);
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        // R1: reset state
        cfg_xfer = 2'd0;
        tick();
        check(level == 0 && !dma_req && !host_irq && !ovr_flag && !und_flag,
              "R1 reset", int'(level), 0);
        rst_n = 1'b1; tick();
        check(level == 0 && !dma_req && !host_irq, "R1 after reset", int'(dma_req), 0);

        // R3, R8, R5, R2, R6: read direction, burst DMA, every code
        for (int c = 0; c < 16; c++) begin
            restart(2'd0, 1'b1, 4'(c), 1'b1, 1'b1);
            for (int i = 1; i <= 16; i++) begin
                push_dsk(pat(i, c));
                check(level == 5'(i), "R2 read fill level", int'(level), i);
                check(dma_req == (i >= 16 - (c + 1)), "R3 read arm", int'(dma_req),
                      int'(i >= 16 - (c + 1)));
                check(!host_irq, "R6 irq quiet in DMA", int'(host_irq), 0);
            end
            for (int i = 1; i <= 16; i++) begin
                check(dma_req, "R8 burst hold", int'(dma_req), 1);
                check(host_rdata == pat(i, c), "R2 read order", int'(host_rdata),
                      int'(pat(i, c)));
                ack_once();
            end
            check(level == 0 && !dma_req, "R5 drop at empty", int'(dma_req), 0);
        end

        // R4, R5, R6, R2: write direction, interrupt mode, every code
        for (int c = 0; c < 16; c++) begin
            restart(2'd1, 1'b1, 4'(c), 1'b0, 1'b0);
            check(host_irq, "R4 write arm at empty", int'(host_irq), 1);
            for (int i = 1; i <= 16; i++) begin
                wr_host(pat(i, c));
                check(host_irq == (i < 16), "R5 write hold until full", int'(host_irq),
                      int'(i < 16));
                check(!dma_req, "R6 no DMA when off", int'(dma_req), 0);
            end
            for (int i = 1; i <= 16; i++) begin
                check(dsk_rdata == pat(i, c), "R2 write order", int'(dsk_rdata),
                      int'(pat(i, c)));
                dsk_pop = 1'b1; tick(); dsk_pop = 1'b0;
                check(host_irq == ((16 - i) <= c + 1), "R4 write rearm", int'(host_irq),
                      int'((16 - i) <= c + 1));
            end
        end

        // R7: single-transfer gap
        restart(2'd0, 1'b1, 4'd3, 1'b1, 1'b0);
        for (int i = 1; i <= 16; i++) push_dsk(pat(i, 9));
        for (int i = 1; i <= 16; i++) begin
            check(dma_req, "R7 request before ack", int'(dma_req), 1);
            ack_once();
            check(!dma_req, "R7 gap after ack", int'(dma_req), 0);
            tick();
        end
        check(level == 0 && !dma_req, "R7 drained", int'(level), 0);

        // R9: verify drains without host data
        restart(2'd2, 1'b1, 4'd15, 1'b1, 1'b1);
        for (int i = 1; i <= 4; i++) push_dsk(8'hA0 + 8'(i));
        for (int i = 1; i <= 4; i++) begin
            check(host_rdata == 8'h00, "R9 verify data quiet", int'(host_rdata), 0);
            check(dma_req, "R3 verify arm", int'(dma_req), 1);
            ack_once();
            check(level == 5'(4 - i), "R9 verify consumes", int'(level), 4 - i);
        end

        // R10: one-byte mode, read and write
        restart(2'd0, 1'b0, 4'd0, 1'b0, 1'b0);
        check(!host_irq, "R10 read idle", int'(host_irq), 0);
        push_dsk(8'h5A);
        check(host_irq && level == 1, "R10 read one byte", int'(host_irq), 1);
        host_rd = 1'b1; tick(); host_rd = 1'b0;
        check(!host_irq && level == 0, "R10 read drained", int'(host_irq), 0);
        restart(2'd1, 1'b0, 4'd0, 1'b0, 1'b0);
        check(host_irq, "R10 write empty request", int'(host_irq), 1);
        wr_host(8'h33);
        check(!host_irq && level == 1, "R10 write held", int'(host_irq), 0);
        wr_host(8'h44);
        check(level == 1 && dsk_rdata == 8'h33, "R13 write to full ignored",
              int'(dsk_rdata), 'h33);
        dsk_pop = 1'b1; tick(); dsk_pop = 1'b0;
        check(host_irq && level == 0, "R10 write rearm", int'(host_irq), 1);

        // R11: overrun
        restart(2'd0, 1'b1, 4'd0, 1'b0, 1'b0);
        for (int i = 1; i <= 16; i++) push_dsk(pat(i, 2));
        check(!ovr_flag, "R11 no overrun at full", int'(ovr_flag), 0);
        push_dsk(8'hEE);
        check(ovr_flag && level == 16, "R11 overrun", int'(level), 16);
        tick(); tick();
        check(ovr_flag, "R11 overrun sticky", int'(ovr_flag), 1);
        check(host_rdata == pat(1, 2), "R11 head kept", int'(host_rdata), int'(pat(1, 2)));

        // R12: underrun
        restart(2'd1, 1'b1, 4'd0, 1'b0, 1'b0);
        dsk_pop = 1'b1; tick(); dsk_pop = 1'b0;
        check(und_flag && level == 0, "R12 underrun", int'(und_flag), 1);
        tick();
        check(und_flag, "R12 underrun sticky", int'(und_flag), 1);

        // R13: host read from empty
        restart(2'd0, 1'b1, 4'd0, 1'b0, 1'b0);
        host_rd = 1'b1; tick(); host_rd = 1'b0;
        check(level == 0 && !und_flag, "R13 read from empty ignored", int'(level), 0);
        push_dsk(8'h77);
        check(level == 1 && host_rdata == 8'h77, "R13 level intact", int'(host_rdata), 'h77);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule